// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small in-order processor core that runs a reduced 32-bit integer instruction subset: register add, subtract, bitwise AND and OR, plus word load and word store. Each instruction moves through fetch, decode, execute, memory and writeback, with a register stage between every pair of neighbours. Control is decoded once from the opcode. It then travels as three bundles: one for execute, one for memory and one for writeback. Each bundle is dropped after the stage that consumes it. The destination register number rides with its instruction, so a result lands in the register its own instruction named.

The instruction store, register file and data store are internal arrays. A program port loads instruction words. Reset clears every stage to a bubble and preloads the register file and data store with known values, so a test program produces predictable results. Writebacks and stores appear on observation outputs. The core has no hazard detection, forwarding or branching. Programs must keep a result from being read by any of the next four instructions.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high every stage holds a bubble with all control deasserted, so `wb_valid` and `st_valid` are 0. On reset, register i (i >= 1) is preloaded with i + 100, register 0 reads 0, and every data word is preloaded with 99.
- R2: The fetch address starts at `START_PC` (default 0) after reset and grows by 4 on every clock edge. The instruction word index is address bits [IAW+1:2], so instructions execute in program-store order.
- R3: Opcode bits [31:26] = 0 selects a register operation by function bits [5:0]: 0x20 add, 0x22 subtract (first minus second), 0x24 AND, 0x25 OR. The sources are fields [25:21] and [20:16], and the destination is field [15:11].
- R4: Opcode 0x23 loads the word at address (source [25:21] + sign-extended bits [15:0]) into the register in field [20:16]. The data word index is address bits [DAW+1:2].
- R5: Opcode 0x2B stores the value of register [20:16] to the same computed address. It shows `st_valid`=1 with `st_addr` and `st_data`, writes no register, and a later load of that word returns the stored value.
- R6: Register 0 is never written (`wb_valid` stays 0 for destination 0), and reading it gives 0.
- R7: The destination number is selected in execute and carried with its instruction, so back-to-back instructions each write their own destination.
- R8: Counting cycle 1 as the fetch cycle of instruction word k (0-based), its store is visible in cycle 4 and its writeback in cycle 5, i.e. after rising edges k+3 and k+4 following reset release. Five back-to-back instructions retire in cycles 5 through 9.
- R9: Any other opcode, or opcode 0 with any other function code (the all-zero word included), behaves as a bubble: no writeback and no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | IAW | Program store word index |
| prog_data | input | 32 | Program word to write |
| wb_valid | output | 1 | A register write happens at the next edge |
| wb_reg | output | 5 | Destination register of that write |
| wb_data | output | 32 | Value being written |
| st_valid | output | 1 | A data store happens at the next edge |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Word being stored |

## Verification
A store of program word k is due on the store outputs after the (k+3)th edge following reset release, and its writeback is due on the writeback outputs after the (k+4)th edge. The bench keeps a table of expected results by program index. It samples at each falling edge n and compares the store outputs against entry n-3 and the writeback outputs against entry n-4. For slots that have no entry yet, or that hold bubbles, both valids must be low. Random programs draw source registers only from ones the program never writes, so in-order reference results match the pipeline without any forwarding.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned RAW  = 5;

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_LOAD = 6'h23;
  localparam logic [5:0] OP_STOR = 6'h2B;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    use_imm;
    alu_op_e alu_op;
    logic    dst_rd;
  } ex_ctl_t;

  typedef struct packed {
    logic rd_en;
    logic wr_en;
  } mem_ctl_t;

  typedef struct packed {
    logic wr_en;
    logic from_mem;
  } wb_ctl_t;

  typedef struct packed {
    ex_ctl_t  ex;
    mem_ctl_t mem;
    wb_ctl_t  wb;
  } ctl_bundle_t;
endpackage

// File: rtl/pipe5_ctl_decode.sv
module pipe5_ctl_decode
  import pipe5_pkg::*;
(
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  output ctl_bundle_t ctl
);
  logic reg_op;

  always_comb begin
    ctl    = '0;
    reg_op = 1'b0;
    case (opcode)
      OP_REG: begin
        reg_op = 1'b1;
        case (funct)
          FN_ADD:  ctl.ex.alu_op = ALU_ADD;
          FN_SUB:  ctl.ex.alu_op = ALU_SUB;
          FN_AND:  ctl.ex.alu_op = ALU_AND;
          FN_OR:   ctl.ex.alu_op = ALU_OR;
          default: reg_op = 1'b0;
        endcase
        if (reg_op) begin
          ctl.ex.dst_rd = 1'b1;
          ctl.wb.wr_en  = 1'b1;
        end
      end
      OP_LOAD: begin
        ctl.ex.use_imm  = 1'b1;
        ctl.ex.alu_op   = ALU_ADD;
        ctl.mem.rd_en   = 1'b1;
        ctl.wb.wr_en    = 1'b1;
        ctl.wb.from_mem = 1'b1;
      end
      OP_STOR: begin
        ctl.ex.use_imm = 1'b1;
        ctl.ex.alu_op  = ALU_ADD;
        ctl.mem.wr_en  = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  // R5: a store never also writes a register or reads memory
  always_comb begin
    p_store_exclusive_r5: assert (!(ctl.mem.wr_en && (ctl.wb.wr_en || ctl.mem.rd_en)));
  end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      default: y = a | b;
    endcase
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned W    = 32,
  parameter int unsigned BASE = 100,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++)
        regs[i] <= (i == 0) ? '0 : W'(BASE + i);
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];

  // R6: register 0 keeps reading zero after reset
  p_reg0_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (ra_a == '0) |-> (rd_a == '0));
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned DMEM_WORDS = 64,
  parameter logic [31:0] START_PC   = 32'h0,
  parameter int unsigned DMEM_FILL  = 99,
  parameter int unsigned REG_BASE   = 100,
  localparam int unsigned IAW = $clog2(IMEM_WORDS),
  localparam int unsigned DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prog_we,
  input  logic [IAW-1:0]  prog_addr,
  input  logic [31:0]     prog_data,
  output logic            wb_valid,
  output logic [RAW-1:0]  wb_reg,
  output logic [31:0]     wb_data,
  output logic            st_valid,
  output logic [31:0]     st_addr,
  output logic [31:0]     st_data
);
  // fetch
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] pc;
  logic [31:0] ifid_instr;

  always_ff @(posedge clk) begin
    if (prog_we) imem[prog_addr] <= prog_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= START_PC;
      ifid_instr <= '0;
    end else begin
      pc         <= pc + 32'd4;
      ifid_instr <= imem[pc[IAW+1:2]];
    end
  end

  // decode
  ctl_bundle_t id_ctl;
  logic [31:0] id_a, id_b, wb_value;
  ctl_bundle_t idex_ctl;
  logic [31:0] idex_a, idex_b, idex_imm;
  logic [RAW-1:0] idex_rt, idex_rd;

  // writeback stage registers, declared here for the register file hookup
  wb_ctl_t        mwb_wb;
  logic [31:0]    mwb_alu, mwb_mem;
  logic [RAW-1:0] mwb_dst;

  pipe5_ctl_decode u_dec (
    .opcode (ifid_instr[31:26]),
    .funct  (ifid_instr[5:0]),
    .ctl    (id_ctl)
  );

  pipe5_regfile #(.NREG(32), .W(32), .BASE(REG_BASE)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .ra_a (ifid_instr[25:21]),
    .ra_b (ifid_instr[20:16]),
    .rd_a (id_a),
    .rd_b (id_b),
    .we   (mwb_wb.wr_en),
    .wa   (mwb_dst),
    .wd   (wb_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idex_ctl <= '0;
      idex_a   <= '0;
      idex_b   <= '0;
      idex_imm <= '0;
      idex_rt  <= '0;
      idex_rd  <= '0;
    end else begin
      idex_ctl <= id_ctl;
      idex_a   <= id_a;
      idex_b   <= id_b;
      idex_imm <= {{16{ifid_instr[15]}}, ifid_instr[15:0]};
      idex_rt  <= ifid_instr[20:16];
      idex_rd  <= ifid_instr[15:11];
    end
  end

  // execute: the execute bundle ends here
  logic [31:0]    ex_y;
  logic [RAW-1:0] ex_dst;
  mem_ctl_t       exm_mem;
  wb_ctl_t        exm_wb;
  logic [31:0]    exm_alu, exm_sdata;
  logic [RAW-1:0] exm_dst;

  pipe5_alu #(.W(32)) u_alu (
    .a  (idex_a),
    .b  (idex_ctl.ex.use_imm ? idex_imm : idex_b),
    .op (idex_ctl.ex.alu_op),
    .y  (ex_y)
  );

  assign ex_dst = idex_ctl.ex.dst_rd ? idex_rd : idex_rt;

  always_ff @(posedge clk) begin
    if (rst) begin
      exm_mem   <= '0;
      exm_wb    <= '0;
      exm_alu   <= '0;
      exm_sdata <= '0;
      exm_dst   <= '0;
    end else begin
      exm_mem         <= idex_ctl.mem;
      exm_wb.wr_en    <= idex_ctl.wb.wr_en && (ex_dst != '0);
      exm_wb.from_mem <= idex_ctl.wb.from_mem;
      exm_alu         <= ex_y;
      exm_sdata       <= idex_b;
      exm_dst         <= ex_dst;
    end
  end

  // memory: the memory bundle ends here
  logic [31:0] dmem [DMEM_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= 32'(DMEM_FILL);
    end else if (exm_mem.wr_en) begin
      dmem[exm_alu[DAW+1:2]] <= exm_sdata;
    end
  end

  always_ff @(posedge clk) begin
    if (exm_mem.rd_en) mwb_mem <= dmem[exm_alu[DAW+1:2]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mwb_wb  <= '0;
      mwb_alu <= '0;
      mwb_dst <= '0;
    end else begin
      mwb_wb  <= exm_wb;
      mwb_alu <= exm_alu;
      mwb_dst <= exm_dst;
    end
  end

  // writeback
  assign wb_value = mwb_wb.from_mem ? mwb_mem : mwb_alu;
  assign wb_valid = mwb_wb.wr_en;
  assign wb_reg   = mwb_dst;
  assign wb_data  = wb_value;
  assign st_valid = exm_mem.wr_en;
  assign st_addr  = exm_alu;
  assign st_data  = exm_sdata;

  logic unused_bits;
  assign unused_bits = ^{pc[1:0], pc[31:IAW+2], ifid_instr[10:6]};

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pc == $past(pc) + 32'd4));

  p_bubble_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wb_valid && !st_valid));

  p_no_reg0_write_r6: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_reg != '0));

  p_store_no_wb_r5: assert property (@(posedge clk) disable iff (rst)
    exm_mem.wr_en |-> !exm_wb.wr_en);

  p_load_uses_mem_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(exm_mem.rd_en)) |-> mwb_wb.from_mem);
endmodule

// File: tb/pipe5_core_tb.sv
`timescale 1ns/1ps
module pipe5_core_tb_top;
  localparam int NW = 64;
  localparam int ND = 64;
  localparam int NPROG = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_we = 1'b0;
  logic [5:0] prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic wb_valid, st_valid;
  logic [4:0] wb_reg;
  logic [31:0] wb_data, st_addr, st_data;

  always #5 clk = ~clk;

  pipe5_core dut_i (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .wb_valid(wb_valid), .wb_reg(wb_reg),
    .wb_data(wb_data), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] prog [NW];
  string       tag  [NW];
  bit          e_wv [NW];
  logic [4:0]  e_wr [NW];
  logic [31:0] e_wd [NW];
  bit          e_sv [NW];
  logic [31:0] e_sa [NW];
  logic [31:0] e_sd [NW];
  logic [31:0] mreg [32];
  logic [31:0] mmem [ND];
  int np = 0;

  function automatic logic [31:0] enc_r(int fn, int rd, int rs, int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rt, int rs, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  // reference model, in program order
  task automatic emit(input logic [31:0] w, input string t);
    logic [5:0] op, fn;
    logic [4:0] rs, rt, rd;
    logic [31:0] a, b, addr;
    op = w[31:26]; fn = w[5:0]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11];
    a = mreg[rs]; b = mreg[rt];
    addr = a + {{16{w[15]}}, w[15:0]};
    prog[np] = w; tag[np] = t;
    e_wv[np] = 0; e_wr[np] = '0; e_wd[np] = '0;
    e_sv[np] = 0; e_sa[np] = '0; e_sd[np] = '0;
    if (op == 6'h00 && (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25)) begin
      e_wr[np] = rd;
      case (fn)
        6'h20: e_wd[np] = a + b;
        6'h22: e_wd[np] = a - b;
        6'h24: e_wd[np] = a & b;
        default: e_wd[np] = a | b;
      endcase
      e_wv[np] = (rd != 0);
    end else if (op == 6'h23) begin
      e_wr[np] = rt;
      e_wd[np] = mmem[addr[7:2]];
      e_wv[np] = (rt != 0);
    end else if (op == 6'h2B) begin
      e_sv[np] = 1; e_sa[np] = addr; e_sd[np] = b;
      mmem[addr[7:2]] = b;
    end
    if (e_wv[np]) mreg[e_wr[np]] = e_wd[np];
    np++;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) mreg[i] = (i == 0) ? 32'd0 : 32'(i + 100);
    for (int i = 0; i < ND; i++) mmem[i] = 32'd99;

    // directed corner cases
    emit(enc_i(6'h23, 8, 29, 4),        "R1 R4 R8");
    emit(enc_r(6'h22, 2, 4, 5),         "R3 R7 R8");
    emit(enc_r(6'h24, 9, 10, 11),       "R3 R7 R8");
    emit(enc_r(6'h25, 16, 17, 18),      "R3 R7 R8");
    emit(enc_r(6'h20, 13, 14, 10),      "R3 R7 R8");
    emit(enc_r(6'h20, 0, 20, 21),       "R6");
    emit(32'hFC00_0000,                 "R9");
    emit(enc_r(6'h27, 3, 20, 21),       "R9");
    emit(enc_i(6'h2B, 22, 20, 8),       "R5");
    emit(32'h0,                         "R9");
    emit(enc_r(6'h20, 12, 0, 22),       "R6");
    emit(enc_i(6'h23, 14, 20, 8),       "R5 R4");
    emit(enc_i(6'h23, 15, 24, -4),      "R4");

    // random independent instructions: sources from {0, 20..31}
    while (np < NPROG) begin
      int kind, rd, rs, rt, off;
      kind = $urandom_range(0, 5);
      rd = $urandom_range(0, 15);
      rs = $urandom_range(19, 31); if (rs == 19) rs = 0;
      rt = $urandom_range(19, 31); if (rt == 19) rt = 0;
      off = 4 * $urandom_range(0, 7) - 8;
      case (kind)
        0: emit(enc_r(6'h20, rd, rs, rt), "R3 R7");
        1: emit(enc_r(6'h22, rd, rs, rt), "R3 R7");
        2: emit(enc_r(6'h24, rd, rs, rt), "R3 R7");
        3: emit(enc_r(6'h25, rd, rs, rt), "R3 R7");
        4: emit(enc_i(6'h23, rd, $urandom_range(20, 31), off), "R4 R7");
        default: emit(enc_i(6'h2B, rt, $urandom_range(20, 31), off), "R5");
      endcase
    end
    while (np < NW) emit(32'h0, "R9");

    // load program while in reset
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = 6'(i); prog_data = prog[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
    check(!wb_valid, "R1", "wb_valid in reset", {31'd0, wb_valid}, 32'd0);
    check(!st_valid, "R1", "st_valid in reset", {31'd0, st_valid}, 32'd0);
    rst = 1'b0;

    // edge n after release: store of word n-3, writeback of word n-4
    for (int n = 1; n <= 63; n++) begin
      int kw, ks;
      @(negedge clk);
      kw = n - 4; ks = n - 3;
      if (kw < 0) begin
        check(!wb_valid, "R8", "early wb_valid", {31'd0, wb_valid}, 32'd0);
      end else begin
        check(wb_valid == e_wv[kw], tag[kw], $sformatf("wb_valid word %0d", kw),
              {31'd0, wb_valid}, {31'd0, e_wv[kw]});
        if (e_wv[kw]) begin
          check(wb_reg == e_wr[kw], tag[kw], $sformatf("wb_reg word %0d", kw),
                {27'd0, wb_reg}, {27'd0, e_wr[kw]});
          check(wb_data == e_wd[kw], tag[kw], $sformatf("wb_data word %0d", kw),
                wb_data, e_wd[kw]);
        end
      end
      if (ks < 0) begin
        check(!st_valid, "R8", "early st_valid", {31'd0, st_valid}, 32'd0);
      end else begin
        check(st_valid == e_sv[ks], (e_sv[ks] ? "R5" : "R9 R2"),
              $sformatf("st_valid word %0d", ks), {31'd0, st_valid}, {31'd0, e_sv[ks]});
        if (e_sv[ks]) begin
          check(st_addr == e_sa[ks], "R5", $sformatf("st_addr word %0d", ks), st_addr, e_sa[ks]);
          check(st_data == e_sd[ks], "R5", $sformatf("st_data word %0d", ks), st_data, e_sd[ks]);
        end
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule